// File: doc/BRIEF.md
# External Bus Cycle Stretch Controller

This block turns one processor access into the sequence of bus clock cycles it needs. A request names the kind of access (byte or word, read or write, vector fetch, or a conditional byte or word access), what sort of memory it targets (internal or external, and whether that memory handles an odd-address word in one cycle), and the byte-address low bit. It also carries the number of chip-select wait states for that address and, for conditional kinds, whether the access turned out to be a free cycle.

Three causes lengthen an access, and they combine. A word is split into two byte transfers when it goes to external memory over an 8-bit data bus, or when it sits at an odd address in a memory that cannot do misaligned words. Each byte or word transfer to external memory is then held for its chip-select wait states. A conditional access that resolves to a free cycle makes no transfer at all and takes exactly one cycle. The controller raises `busy` for the whole access, steps the byte lanes high byte first, and gathers read bytes into a 16-bit result that is flagged by a one-cycle `rd_valid` pulse.

Top module: `bus_stretch_ctrl`

## Requirements
- R1: After reset `busy`, `bus_act`, `bus_we` and `rd_valid` are all low.
- R2: `req_kind` encodes 0 byte read, 1 byte write, 2 word read, 3 word write, 4 vector fetch, 5 conditional byte read, 6 conditional byte write, 7 conditional word read; a byte kind always makes exactly one byte transfer with `bus_wide` low and `bus_addr0` equal to the request's address bit.
- R3: A word (kinds 2, 3, 4, 7) to external memory (`req_ext`=1) with `narrow_bus`=1 makes two byte transfers: first the byte at the request address carrying bits 15:8 (`bus_second`=0), then the byte at the next address carrying bits 7:0 (`bus_second`=1, `bus_addr0` inverted).
- R4: A word of kind 2, 3 or 7 with `req_addr0`=1 and `req_misal_ok`=0 is split the same way as in R3; with `req_misal_ok`=1 and no narrow-bus split it is one wide transfer (`bus_wide`=1) lasting one cycle plus wait states.
- R5: A vector fetch ignores `req_addr0`: it is never split for alignment and drives `bus_addr0`=0 on its first transfer, but it is still split on a narrow external bus.
- R6: When `req_ext`=1, each transfer lasts 1 + `req_cs_wait` cycles, separately for each byte of a split word; when `req_ext`=0 the wait count is ignored and each transfer lasts one cycle.
- R7: Conditional byte kinds 5 and 6 are never split, whatever the bus width; kind 7 stretches and splits like a word read.
- R8: A conditional kind with `req_free`=1 keeps `busy` high for exactly one cycle, makes no transfer (`bus_act` low) and gives no `rd_valid`, regardless of wait states or bus width.
- R9: `busy` is high for exactly the cycles of the access, starting the cycle after acceptance; a request is accepted only while `busy` is low, and request inputs changed while busy do not alter the access in flight.
- R10: A non-free read ends with `rd_valid` high for one cycle, the first cycle after `busy` falls; `rd_data` holds the word (or the byte zero-extended, taken from `bus_rdata[7:0]`) and writes give no `rd_valid`.
- R11: Writes drive `bus_we` during every transfer cycle; a wide word drives all 16 bits of `bus_wdata`, a byte transfer drives its byte on `bus_wdata[7:0]` (the write byte for kinds 1 and 6, bits 15:8 then 7:0 for a split word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken while busy is low |
| req_kind | input | 3 | Access kind (R2 encoding) |
| req_ext | input | 1 | Target is external memory |
| req_misal_ok | input | 1 | Target handles odd-address words in one cycle |
| narrow_bus | input | 1 | External data bus is 8 bits wide |
| req_addr0 | input | 1 | Byte address bit 0 |
| req_cs_wait | input | WAIT_W | Chip-select wait states per transfer |
| req_free | input | 1 | Conditional access resolves to a free cycle |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| bus_act | output | 1 | Bus transfer cycle |
| bus_we | output | 1 | Transfer is a write |
| bus_wide | output | 1 | Transfer moves 16 bits |
| bus_second | output | 1 | Second byte of a split word |
| bus_addr0 | output | 1 | Address bit 0 of the current transfer |
| bus_wdata | output | 16 | Write data of the current transfer |
| bus_rdata | input | 16 | Read data from memory |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 16 | Read result |

## Verification
On every cycle the assertions check that transfers happen only inside a busy window, that a free access lasts a single cycle, that a wait state holds the current byte lane, that the second byte follows a transfer, and that `rd_valid` is a lone pulse right after `busy` falls. Only the bench's scenarios can show the cycle counts for each mix of narrow bus, misalignment and wait states, the high-then-low byte order with its data and addresses, the zero extension of byte reads, and that request inputs scrambled during `busy` leave the access untouched.

// File: rtl/bus_stretch_ctrl.sv
`timescale 1ns/1ps
module bus_stretch_ctrl #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic              req_ext,
  input  logic              req_misal_ok,
  input  logic              narrow_bus,
  input  logic              req_addr0,
  input  logic [WAIT_W-1:0] req_cs_wait,
  input  logic              req_free,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              bus_act,
  output logic              bus_we,
  output logic              bus_wide,
  output logic              bus_second,
  output logic              bus_addr0,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data
);

  localparam logic [2:0] K_RD8  = 3'd0;
  localparam logic [2:0] K_WR8  = 3'd1;
  localparam logic [2:0] K_RD16 = 3'd2;
  localparam logic [2:0] K_WR16 = 3'd3;
  localparam logic [2:0] K_VEC  = 3'd4;
  localparam logic [2:0] K_CRD8 = 3'd5;
  localparam logic [2:0] K_CWR8 = 3'd6;
  localparam logic [2:0] K_CRD16 = 3'd7;

  logic is_word, is_cond, is_wr, is_vec, misal, split_d, free_d;
  logic [WAIT_W-1:0] wst_d;

  assign is_word = (req_kind == K_RD16) | (req_kind == K_WR16) |
                   (req_kind == K_VEC)  | (req_kind == K_CRD16);
  assign is_cond = (req_kind == K_CRD8) | (req_kind == K_CWR8) | (req_kind == K_CRD16);
  assign is_wr   = (req_kind == K_WR8) | (req_kind == K_WR16) | (req_kind == K_CWR8);
  assign is_vec  = (req_kind == K_VEC);
  assign misal   = ~is_vec & req_addr0 & ~req_misal_ok;
  assign split_d = is_word & ((req_ext & narrow_bus) | misal);
  assign free_d  = is_cond & req_free;
  assign wst_d   = req_ext ? req_cs_wait : '0;

  logic busy_q, free_q, two_q, wide_q, we_q, a0_q, ph_q, vld_q;
  logic [WAIT_W-1:0] wait_q, cnt_q;
  logic [15:0] wd_q, rb_q;

  logic acc, act, beat_end;
  assign acc      = req_valid & ~busy_q;
  assign act      = busy_q & ~free_q;
  assign beat_end = act & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      free_q <= 1'b0;
      two_q  <= 1'b0;
      wide_q <= 1'b0;
      we_q   <= 1'b0;
      a0_q   <= 1'b0;
      ph_q   <= 1'b0;
      vld_q  <= 1'b0;
      wait_q <= '0;
      cnt_q  <= '0;
      wd_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (acc) begin
        busy_q <= 1'b1;
        free_q <= free_d;
        two_q  <= split_d;
        wide_q <= is_word & ~split_d;
        we_q   <= is_wr;
        a0_q   <= req_addr0 & ~is_vec;
        ph_q   <= 1'b0;
        wait_q <= wst_d;
        cnt_q  <= wst_d;
        wd_q   <= req_wdata;
      end else if (busy_q) begin
        if (free_q) begin
          busy_q <= 1'b0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (two_q && !ph_q) begin
          ph_q  <= 1'b1;
          cnt_q <= wait_q;
        end else begin
          busy_q <= 1'b0;
          vld_q  <= ~we_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= '0;
    end else if (beat_end && !we_q) begin
      if (wide_q)     rb_q <= bus_rdata;
      else if (!two_q) rb_q <= {8'h00, bus_rdata[7:0]};
      else if (!ph_q) rb_q[15:8] <= bus_rdata[7:0];
      else            rb_q[7:0]  <= bus_rdata[7:0];
    end
  end

  assign busy       = busy_q;
  assign bus_act    = act;
  assign bus_we     = act & we_q;
  assign bus_wide   = act & wide_q;
  assign bus_second = act & ph_q;
  assign bus_addr0  = act & (a0_q ^ ph_q);
  assign bus_wdata  = !act   ? 16'h0000 :
                      wide_q ? wd_q :
                      {8'h00, (two_q && !ph_q) ? wd_q[15:8] : wd_q[7:0]};
  assign rd_valid   = vld_q;
  assign rd_data    = rb_q;

  // R9: transfers only inside an access
  p_act_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |-> busy);

  // R8: a free access lasts a single cycle
  p_free_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && free_q) |=> !busy_q);

  // R6: a wait state keeps the same byte lane on the bus
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt_q != '0) |=> (bus_act && $stable(bus_second)));

  // R3: the second byte follows a transfer of the same access
  p_second_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_second) |-> ($past(bus_act) && !bus_wide));

  // R10: result pulse is single and follows the busy window
  p_vld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_vld_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)));

endmodule

// File: tb/bus_stretch_ctrl_test.sv
`timescale 1ns/1ps
module bus_stretch_ctrl_test;
  localparam int WAIT_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic req_ext = 1'b0, req_misal_ok = 1'b0, narrow_bus = 1'b0, req_addr0 = 1'b0, req_free = 1'b0;
  logic [WAIT_W-1:0] req_cs_wait = '0;
  logic [15:0] req_wdata = '0;
  logic busy, bus_act, bus_we, bus_wide, bus_second, bus_addr0, rd_valid;
  logic [15:0] bus_wdata, bus_rdata, rd_data;
  logic [15:0] mem_word = 16'h0000;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign bus_rdata = bus_wide ? mem_word :
                     bus_second ? {8'hA5, mem_word[7:0]} : {8'h5A, mem_word[15:8]};

  bus_stretch_ctrl #(.WAIT_W(WAIT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_ext(req_ext), .req_misal_ok(req_misal_ok), .narrow_bus(narrow_bus),
    .req_addr0(req_addr0), .req_cs_wait(req_cs_wait), .req_free(req_free),
    .req_wdata(req_wdata), .busy(busy), .bus_act(bus_act), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_second(bus_second), .bus_addr0(bus_addr0),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit f_word(bit [2:0] k);
    return (k == 3'd2) || (k == 3'd3) || (k == 3'd4) || (k == 3'd7);
  endfunction

  function automatic bit f_wr(bit [2:0] k);
    return (k == 3'd1) || (k == 3'd3) || (k == 3'd6);
  endfunction

  function automatic int f_beats(bit [2:0] k, bit ext, bit mok, bit nar, bit a0, bit fr);
    if (k >= 3'd5 && fr) return 0;
    if (f_word(k) && ((ext && nar) || (k != 3'd4 && a0 && !mok))) return 2;
    return 1;
  endfunction

  task automatic run_access(bit [2:0] k, bit ext, bit mok, bit nar, bit a0,
                            bit [WAIT_W-1:0] cs, bit fr, bit [15:0] wd, bit [15:0] mw);
    int cyc = 0, nact = 0, nsec = 0, nwe = 0, nwide = 0;
    int beats, w, exp_cyc;
    bit [15:0] wd0 = '0, wd1 = '0;
    bit ad0 = 1'b0, ad1 = 1'b0, idle = 1'b0;
    bit wr = f_wr(k);
    beats = f_beats(k, ext, mok, nar, a0, fr);
    w = ext ? int'(cs) : 0;
    exp_cyc = (beats == 0) ? 1 : beats * (1 + w);
    @(negedge clk);
    req_kind = k; req_ext = ext; req_misal_ok = mok; narrow_bus = nar;
    req_addr0 = a0; req_cs_wait = cs; req_free = fr; req_wdata = wd;
    mem_word = mw; req_valid = 1'b1;
    while (!idle) begin
      @(negedge clk);
      if (!busy && cyc > 0) begin
        idle = 1'b1;
      end else if (busy) begin
        cyc++;
        req_kind = 3'($urandom); req_ext = 1'($urandom); req_misal_ok = 1'($urandom);
        narrow_bus = 1'($urandom); req_addr0 = 1'($urandom); req_cs_wait = WAIT_W'($urandom);
        req_free = 1'($urandom); req_wdata = 16'($urandom);
        if (bus_act) begin
          nact++;
          if (bus_we) nwe++;
          if (bus_wide) nwide++;
          if (bus_second) begin nsec++; wd1 = bus_wdata; ad1 = bus_addr0; end
          else begin wd0 = bus_wdata; ad0 = bus_addr0; end
        end
      end
      if (cyc > 40 || (!busy && cyc == 0 && !idle && req_valid == 1'b0)) idle = 1'b1;
      if (!busy && cyc == 0) cyc = -1000;
    end
    // R9: busy spans exactly the access; R6 wait states per transfer
    check("R9", "busy cycles", cyc, exp_cyc);
    check("R6", "transfer cycles", nact, beats * (1 + w));
    check("R3", "second-byte cycles", nsec, (beats == 2) ? 1 + w : 0);
    check("R11", "write cycles", nwe, wr ? beats * (1 + w) : 0);
    check("R4", "wide cycles", nwide, (beats == 1 && f_word(k)) ? 1 + w : 0);
    check("R10", "rd_valid", int'(rd_valid), (beats > 0 && !wr) ? 1 : 0);
    if (beats > 0) begin
      check("R5", "first addr0", int'(ad0), (k == 3'd4) ? 0 : int'(a0));
      if (beats == 2) check("R3", "second addr0", int'(ad1), (k == 3'd4) ? 1 : int'(!a0));
      if (!wr) begin
        check("R10", "rd_data", int'(rd_data), f_word(k) ? int'(mw) : int'({8'h00, mw[15:8]}));
      end else if (beats == 2) begin
        check("R11", "first byte", int'(wd0[7:0]), int'(wd[15:8]));
        check("R11", "second byte", int'(wd1[7:0]), int'(wd[7:0]));
      end else if (f_word(k)) begin
        check("R11", "wide data", int'(wd0), int'(wd));
      end else begin
        check("R2", "byte data", int'(wd0[7:0]), int'(wd[7:0]));
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R9", "no accept while busy", int'(busy), 0);
    check("R10", "rd_valid single", int'(rd_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "bus_act in reset", int'(bus_act), 0);
    check("R1", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "bus_we after reset", int'(bus_we), 0);
    // R2 byte read, internal
    run_access(3'd0, 0, 0, 0, 1, 2'd3, 0, 16'h0000, 16'hC3E1);
    // R2 byte write, external slow narrow
    run_access(3'd1, 1, 0, 1, 0, 2'd2, 0, 16'h12F0, 16'h0000);
    // R3 narrow external word read and write
    run_access(3'd2, 1, 1, 1, 0, 2'd0, 0, 16'h0000, 16'hBEEF);
    run_access(3'd3, 1, 1, 1, 1, 2'd1, 0, 16'hA1B2, 16'h0000);
    // R4 misaligned, not tolerated vs tolerated
    run_access(3'd2, 0, 0, 0, 1, 2'd3, 0, 16'h0000, 16'h1357);
    run_access(3'd2, 0, 1, 0, 1, 2'd3, 0, 16'h0000, 16'h2468);
    // R5 vector: odd bit ignored, wide bus; narrow bus split
    run_access(3'd4, 0, 0, 0, 1, 2'd0, 0, 16'h0000, 16'hFFFE);
    run_access(3'd4, 1, 0, 1, 1, 2'd3, 0, 16'h0000, 16'h8001);
    // R6 max wait on each byte; internal ignores wait count
    run_access(3'd3, 1, 0, 1, 0, 2'd3, 0, 16'h5AA5, 16'h0000);
    run_access(3'd3, 0, 1, 1, 0, 2'd3, 0, 16'h7E81, 16'h0000);
    // R7 conditional bytes never split, conditional word splits
    run_access(3'd5, 1, 0, 1, 1, 2'd1, 0, 16'h0000, 16'h9A00);
    run_access(3'd6, 1, 0, 1, 1, 2'd2, 0, 16'h00C7, 16'h0000);
    run_access(3'd7, 1, 0, 1, 0, 2'd2, 0, 16'h0000, 16'h4321);
    // R8 free cycles ignore stretch causes
    run_access(3'd7, 1, 0, 1, 1, 2'd3, 1, 16'h0000, 16'h1111);
    run_access(3'd6, 1, 0, 1, 0, 2'd3, 1, 16'hFFFF, 16'h0000);
    run_access(3'd5, 0, 0, 0, 0, 2'd0, 1, 16'h0000, 16'h2222);
    // R9 req_free on a non-conditional kind has no effect
    run_access(3'd2, 1, 1, 0, 0, 2'd1, 1, 16'h0000, 16'h3333);
    for (int i = 0; i < 400; i++) begin
      run_access(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 WAIT_W'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule